// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block runs one SMBus host transaction at a time. Software programs the slave address, the command byte, the data bytes and the byte count through a byte-wide register port. It then writes a protocol code to start the transaction. The sequencer turns that code into a series of byte-level primitives and hands them, one at a time, to a separate bit-level bus engine. The primitives are start, write byte, read byte with ACK, read byte with NACK, and stop.

When the transaction ends, the sequencer writes a five-bit result code and a done flag into the status register. It then returns the protocol register to zero, and software polls for that zero to detect completion. Read data and the slave-returned block length are stored in the same data and count registers that software reads afterwards. Bit timing, checksum generation and alarm reception belong to other blocks.

Top module: `smb_host_seq`

## Requirements
- R1: After reset every register reads 0x00 and `op_valid_o` is low.
- R2: A nonzero write to the protocol register (offset 0x00) while it reads zero starts a transaction. The protocol register keeps its value while the transaction runs and reads 0x00 once it has ended. At the end, status (offset 0x01) holds bit 7 = 1, bit 6 unchanged, bit 5 = 0 and the result code in bits 4:0. No primitive is requested while the protocol register is zero.
- R3: Each primitive is offered on `op_valid_o`/`op_kind_o`/`op_wdata_o` and held stable until `op_done_i`. The kind codes are 0 start, 1 write byte, 2 read with ACK, 3 read with NACK and 4 stop. Quick (0x02 write, 0x03 read) issues start, then address byte {addr[7:1], protocol bit 0}, then stop.
- R4: Send-byte (0x04), byte-data write (0x06) and word write (0x08) issue start, the address with bit 0 = 0, the command, then 0, 1 or 2 data bytes taken from data offset 0 upward, then stop.
- R5: A read that follows a command (0x07, 0x09, 0x0B) issues a repeated start and the address with bit 0 = 1. Receive-byte (0x05) sends the address with bit 0 = 1 directly. Every read is ACKed except the last, which is NACKed.
- R6: Word data keeps the low byte at data offset 0 (register 0x04) and the high byte at offset 1 (register 0x05).
- R7: Block write (0x0A) sends the count register (offset 0x24) and then that many data bytes. If the count is 0 or above DATA_BYTES, the transaction ends with result 0x13 and no bus primitive.
- R8: Block read (0x0B) reads the length byte from the slave, stores it in the count register and then reads that many data bytes. A length of 0 or above DATA_BYTES ends with a stop and result 0x11.
- R9: Process call (0x0C) writes data offsets 0 and 1, then performs a repeated start and reads two bytes back into offsets 0 and 1.
- R10: A NACK on either address byte ends the transaction with a stop and result 0x10.
- R11: A protocol code, bits 6:0, outside 0x02..0x0D completes with result 0x19 and no bus primitive.
- R12: Protocol writes during a running transaction have no effect.
- R13: The address (0x02), command (0x03), data (0x04..), count (0x24) and alarm registers (0x25..0x27) read back the last value the host wrote.
- R14: A NACK on a command, count or data byte ends the transaction with a stop and result 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (6) | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| op_valid_o | output | 1 | Primitive request to the bus engine |
| op_kind_o | output | 3 | Primitive kind |
| op_wdata_o | output | 8 | Byte to transmit for a write primitive |
| op_done_i | input | 1 | Bus engine finished the offered primitive |
| op_nack_i | input | 1 | Slave NACKed the written byte (with `op_done_i`) |
| op_rdata_i | input | 8 | Byte received (with `op_done_i`) |

## Verification
The bench builds the block with its default DATA_BYTES of 32. A bus-engine model adds a one-cycle gap before each acknowledgement. With that size, a full 32-byte block write and the rejection of a length of 33 are both reachable, so both ends of the block-length window can be tested. The engine model also NACKs selected bytes and returns scripted read bytes. This exercises every error exit and checks the order of the primitives on the engine side against the requirements.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_WRITE   = 3'd1,
    OP_RD_ACK  = 3'd2,
    OP_RD_NACK = 3'd3,
    OP_STOP    = 3'd4
  } op_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR1, ST_CMD, ST_WCNT, ST_WDATA,
    ST_RSTART, ST_ADDR2, ST_RCNT, ST_RDATA, ST_STOP, ST_FIN
  } seq_state_e;

  localparam logic [4:0] RC_OK     = 5'h00;
  localparam logic [4:0] RC_NOACK  = 5'h10;
  localparam logic [4:0] RC_DEVERR = 5'h11;
  localparam logic [4:0] RC_HOSTER = 5'h13;
  localparam logic [4:0] RC_UNSUP  = 5'h19;

  typedef struct packed {
    logic       legal;
    logic       addr_only;  // no command phase, address carries R/W
    logic       send_cmd;
    logic [1:0] wr_n;
    logic       wr_blk;
    logic [1:0] rd_n;
    logic       rd_blk;
  } plan_t;

  function automatic plan_t decode_proto(input logic [7:0] p);
    plan_t d;
    d = '0;
    d.legal = 1'b1;
    case (p[6:0])
      7'h02, 7'h03: d.addr_only = 1'b1;
      7'h04: d.send_cmd = 1'b1;
      7'h05: begin d.addr_only = 1'b1; d.rd_n = 2'd1; end
      7'h06: begin d.send_cmd = 1'b1; d.wr_n = 2'd1; end
      7'h07: begin d.send_cmd = 1'b1; d.rd_n = 2'd1; end
      7'h08: begin d.send_cmd = 1'b1; d.wr_n = 2'd2; end
      7'h09: begin d.send_cmd = 1'b1; d.rd_n = 2'd2; end
      7'h0A: begin d.send_cmd = 1'b1; d.wr_blk = 1'b1; end
      7'h0B: begin d.send_cmd = 1'b1; d.rd_blk = 1'b1; end
      7'h0C: begin d.send_cmd = 1'b1; d.wr_n = 2'd2; d.rd_n = 2'd2; end
      7'h0D: begin d.send_cmd = 1'b1; d.wr_blk = 1'b1; d.rd_blk = 1'b1; end
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/smb_reg_file.sv
module smb_reg_file
  import smb_host_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int ADDR_W     = 6,
  parameter int IDX_W      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  output logic [7:0]        host_rdata_o,
  output logic [7:0]        proto_o,
  output logic [7:0]        status_o,
  output logic [7:0]        addr_o,
  output logic [7:0]        cmd_o,
  output logic [7:0]        bcnt_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [7:0]        rd_byte_o,
  input  logic              seq_fin_i,
  input  logic              seq_sts_clr_i,
  input  logic [4:0]        seq_code_i,
  input  logic              seq_dwe_i,
  input  logic [IDX_W-1:0]  seq_didx_i,
  input  logic [7:0]        seq_dval_i,
  input  logic              seq_cwe_i,
  input  logic [7:0]        seq_cval_i
);
  localparam int DATA_BASE = 4;
  localparam int CNT_OFF   = DATA_BASE + DATA_BYTES;
  localparam int ALM_OFF   = CNT_OFF + 1;

  logic [7:0] proto_q, status_q, addr_q, cmd_q, bcnt_q, alm_a_q;
  logic [7:0] alm_d_q [2];
  logic [7:0] data_q [DATA_BYTES];

  logic              in_data;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  hidx;

  assign in_data = (host_addr_i >= ADDR_W'(DATA_BASE)) && (host_addr_i < ADDR_W'(CNT_OFF));
  assign off     = host_addr_i - ADDR_W'(DATA_BASE);
  assign hidx    = off[IDX_W-1:0];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int o);
    return a == ADDR_W'(o);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      proto_q  <= '0;
      status_q <= '0;
      addr_q   <= '0;
      cmd_q    <= '0;
      bcnt_q   <= '0;
      alm_a_q  <= '0;
      alm_d_q[0] <= '0;
      alm_d_q[1] <= '0;
    end else begin
      if (seq_fin_i) proto_q <= '0;
      else if (host_we_i && hit(host_addr_i, 0) && proto_q == 8'h00) proto_q <= host_wdata_i;

      if (seq_fin_i) status_q <= {1'b1, status_q[6], 1'b0, seq_code_i};
      else if (seq_sts_clr_i) status_q <= {1'b0, status_q[6], 6'b0};
      else if (host_we_i && hit(host_addr_i, 1)) status_q <= host_wdata_i;

      if (seq_cwe_i) bcnt_q <= seq_cval_i;
      else if (host_we_i && hit(host_addr_i, CNT_OFF)) bcnt_q <= host_wdata_i;

      if (host_we_i) begin
        if (hit(host_addr_i, 2))           addr_q     <= host_wdata_i;
        if (hit(host_addr_i, 3))           cmd_q      <= host_wdata_i;
        if (hit(host_addr_i, ALM_OFF))     alm_a_q    <= host_wdata_i;
        if (hit(host_addr_i, ALM_OFF + 1)) alm_d_q[0] <= host_wdata_i;
        if (hit(host_addr_i, ALM_OFF + 2)) alm_d_q[1] <= host_wdata_i;
      end
    end
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_q[g] <= '0;
      else if (seq_dwe_i && seq_didx_i == IDX_W'(g)) data_q[g] <= seq_dval_i;
      else if (host_we_i && in_data && hidx == IDX_W'(g)) data_q[g] <= host_wdata_i;
    end
  end

  always_comb begin
    host_rdata_o = '0;
    if (hit(host_addr_i, 0))                host_rdata_o = proto_q;
    else if (hit(host_addr_i, 1))           host_rdata_o = status_q;
    else if (hit(host_addr_i, 2))           host_rdata_o = addr_q;
    else if (hit(host_addr_i, 3))           host_rdata_o = cmd_q;
    else if (in_data)                       host_rdata_o = data_q[hidx];
    else if (hit(host_addr_i, CNT_OFF))     host_rdata_o = bcnt_q;
    else if (hit(host_addr_i, ALM_OFF))     host_rdata_o = alm_a_q;
    else if (hit(host_addr_i, ALM_OFF + 1)) host_rdata_o = alm_d_q[0];
    else if (hit(host_addr_i, ALM_OFF + 2)) host_rdata_o = alm_d_q[1];
  end

  assign proto_o   = proto_q;
  assign status_o  = status_q;
  assign addr_o    = addr_q;
  assign cmd_o     = cmd_q;
  assign bcnt_o    = bcnt_q;
  assign rd_byte_o = data_q[rd_idx_i];

endmodule

// File: rtl/smb_txn_fsm.sv
module smb_txn_fsm
  import smb_host_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int IDX_W      = 5,
  parameter int CNT_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       proto_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       cmd_i,
  input  logic [7:0]       bcnt_i,
  input  logic [7:0]       rd_byte_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             op_valid_o,
  output op_kind_e         op_kind_o,
  output logic [7:0]       op_wdata_o,
  input  logic             op_done_i,
  input  logic             op_nack_i,
  input  logic [7:0]       op_rdata_i,
  output logic             fin_o,
  output logic             sts_clr_o,
  output logic [4:0]       code_o,
  output logic             dwe_o,
  output logic [7:0]       dval_o,
  output logic             cwe_o,
  output logic [7:0]       cval_o
);
  localparam logic [7:0] MAX_CNT = 8'(DATA_BYTES);

  seq_state_e       state_q;
  logic [CNT_W-1:0] pos_q, len_q;
  logic [4:0]       code_q;
  plan_t            plan;
  logic             reads, last, blk_bad, rcnt_bad;

  assign plan     = decode_proto(proto_i);
  assign reads    = (plan.rd_n != 2'd0) || plan.rd_blk;
  assign last     = (pos_q + CNT_W'(1)) == len_q;
  assign blk_bad  = (bcnt_i == 8'h00) || (bcnt_i > MAX_CNT);
  assign rcnt_bad = (op_rdata_i == 8'h00) || (op_rdata_i > MAX_CNT);

  always_comb begin
    op_valid_o = !(state_q inside {ST_IDLE, ST_FIN});
    op_kind_o  = OP_WRITE;
    op_wdata_o = '0;
    case (state_q)
      ST_START, ST_RSTART: op_kind_o = OP_START;
      ST_STOP:  op_kind_o = OP_STOP;
      ST_RCNT:  op_kind_o = OP_RD_ACK;
      ST_RDATA: op_kind_o = last ? OP_RD_NACK : OP_RD_ACK;
      ST_ADDR1: op_wdata_o = {addr_i[7:1], plan.addr_only & proto_i[0]};
      ST_ADDR2: op_wdata_o = {addr_i[7:1], 1'b1};
      ST_CMD:   op_wdata_o = cmd_i;
      ST_WCNT:  op_wdata_o = bcnt_i;
      ST_WDATA: op_wdata_o = rd_byte_i;
      default: ;
    endcase
  end

  assign rd_idx_o  = pos_q[IDX_W-1:0];
  assign fin_o     = state_q == ST_FIN;
  assign sts_clr_o = (state_q == ST_IDLE) && (proto_i != 8'h00);
  assign code_o    = code_q;
  assign dwe_o     = (state_q == ST_RDATA) && op_done_i;
  assign dval_o    = op_rdata_i;
  assign cwe_o     = (state_q == ST_RCNT) && op_done_i;
  assign cval_o    = op_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      len_q   <= '0;
      code_q  <= RC_OK;
    end else begin
      case (state_q)
        ST_IDLE: if (proto_i != 8'h00) begin
          code_q <= RC_OK;
          if (!plan.legal) begin
            code_q <= RC_UNSUP; state_q <= ST_FIN;
          end else if (plan.wr_blk && blk_bad) begin
            code_q <= RC_HOSTER; state_q <= ST_FIN;
          end else state_q <= ST_START;
        end
        ST_START: if (op_done_i) state_q <= ST_ADDR1;
        ST_ADDR1: if (op_done_i) begin
          if (op_nack_i) begin
            code_q <= RC_NOACK; state_q <= ST_STOP;
          end else if (plan.addr_only) begin
            pos_q <= '0;
            len_q <= CNT_W'(plan.rd_n);
            state_q <= (plan.rd_n != 2'd0) ? ST_RDATA : ST_STOP;
          end else state_q <= ST_CMD;
        end
        ST_CMD: if (op_done_i) begin
          pos_q <= '0;
          len_q <= CNT_W'(plan.wr_n);
          if (op_nack_i) begin
            code_q <= RC_DEVERR; state_q <= ST_STOP;
          end else if (plan.wr_blk)        state_q <= ST_WCNT;
          else if (plan.wr_n != 2'd0)      state_q <= ST_WDATA;
          else if (reads)                  state_q <= ST_RSTART;
          else                             state_q <= ST_STOP;
        end
        ST_WCNT: if (op_done_i) begin
          pos_q <= '0;
          len_q <= bcnt_i[CNT_W-1:0];
          if (op_nack_i) begin
            code_q <= RC_DEVERR; state_q <= ST_STOP;
          end else state_q <= ST_WDATA;
        end
        ST_WDATA: if (op_done_i) begin
          if (op_nack_i) begin
            code_q <= RC_DEVERR; state_q <= ST_STOP;
          end else if (last) state_q <= reads ? ST_RSTART : ST_STOP;
          else pos_q <= pos_q + CNT_W'(1);
        end
        ST_RSTART: if (op_done_i) state_q <= ST_ADDR2;
        ST_ADDR2: if (op_done_i) begin
          pos_q <= '0;
          len_q <= CNT_W'(plan.rd_n);
          if (op_nack_i) begin
            code_q <= RC_NOACK; state_q <= ST_STOP;
          end else state_q <= plan.rd_blk ? ST_RCNT : ST_RDATA;
        end
        ST_RCNT: if (op_done_i) begin
          pos_q <= '0;
          len_q <= op_rdata_i[CNT_W-1:0];
          if (rcnt_bad) begin
            code_q <= RC_DEVERR; state_q <= ST_STOP;
          end else state_q <= ST_RDATA;
        end
        ST_RDATA: if (op_done_i) begin
          if (last) state_q <= ST_STOP;
          else pos_q <= pos_q + CNT_W'(1);
        end
        ST_STOP: if (op_done_i) state_q <= ST_FIN;
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
  import smb_host_pkg::*;
#(
  parameter  int DATA_BYTES = 32,
  localparam int ADDR_W     = $clog2(DATA_BYTES + 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              op_valid_o,
  output logic [2:0]        op_kind_o,
  output logic [7:0]        op_wdata_o,
  input  logic              op_done_i,
  input  logic              op_nack_i,
  input  logic [7:0]        op_rdata_i
);
  localparam int IDX_W = $clog2(DATA_BYTES);
  localparam int CNT_W = $clog2(DATA_BYTES + 1);

  logic [7:0]       proto_w, status_w, addr_w, cmd_w, bcnt_w, rd_byte_w;
  logic [IDX_W-1:0] rd_idx_w;
  logic             fin_w, sts_clr_w, dwe_w, cwe_w;
  logic [4:0]       code_w;
  logic [7:0]       dval_w, cval_w;
  op_kind_e         kind_w;

  smb_reg_file #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_we_i(reg_we_i), .host_addr_i(reg_addr_i), .host_wdata_i(reg_wdata_i),
    .host_rdata_o(reg_rdata_o),
    .proto_o(proto_w), .status_o(status_w), .addr_o(addr_w), .cmd_o(cmd_w),
    .bcnt_o(bcnt_w), .rd_idx_i(rd_idx_w), .rd_byte_o(rd_byte_w),
    .seq_fin_i(fin_w), .seq_sts_clr_i(sts_clr_w), .seq_code_i(code_w),
    .seq_dwe_i(dwe_w), .seq_didx_i(rd_idx_w), .seq_dval_i(dval_w),
    .seq_cwe_i(cwe_w), .seq_cval_i(cval_w)
  );

  smb_txn_fsm #(.DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .proto_i(proto_w), .addr_i(addr_w), .cmd_i(cmd_w), .bcnt_i(bcnt_w),
    .rd_byte_i(rd_byte_w), .rd_idx_o(rd_idx_w),
    .op_valid_o(op_valid_o), .op_kind_o(kind_w), .op_wdata_o(op_wdata_o),
    .op_done_i(op_done_i), .op_nack_i(op_nack_i), .op_rdata_i(op_rdata_i),
    .fin_o(fin_w), .sts_clr_o(sts_clr_w), .code_o(code_w),
    .dwe_o(dwe_w), .dval_o(dval_w), .cwe_o(cwe_w), .cval_o(cval_w)
  );

  assign op_kind_o = kind_w;

endmodule

// File: rtl/smb_host_seq_chk.sv
module smb_host_seq_chk
  import smb_host_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] proto_i,
  input logic [7:0] status_i,
  input logic       fin_i,
  input logic       op_valid_i,
  input logic [2:0] op_kind_i,
  input logic       op_done_i
);
  plan_t pl;
  assign pl = decode_proto(proto_i);

  // R12
  proto_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proto_i != 8'h00 && !fin_i) |=> proto_i == $past(proto_i));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> proto_i != 8'h00);

  // R2
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[7]) |-> proto_i == 8'h00);

  // R3
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !op_done_i) |=> (op_valid_i && $stable(op_kind_i)));

  // R3
  op_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |-> op_kind_i <= 3'd4);

  // R11
  unsup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proto_i != 8'h00 && !pl.legal) |-> !op_valid_i);

endmodule

bind smb_host_seq smb_host_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .proto_i(proto_w), .status_i(status_w),
  .fin_i(fin_w), .op_valid_i(op_valid_o), .op_kind_i(op_kind_o), .op_done_i(op_done_i)
);

// File: tb/smb_host_seq_tb.sv
module smb_host_seq_tb;
  localparam int DB = 32;
  localparam int AW = 6;
  localparam int CNT = 4 + DB;
  localparam int ENG_GAP = 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [7:0]    reg_wdata_i = '0;
  logic [7:0]    reg_rdata_o;
  logic          op_valid_o;
  logic [2:0]    op_kind_o;
  logic [7:0]    op_wdata_o;
  logic          op_done_i = 1'b0;
  logic          op_nack_i = 1'b0;
  logic [7:0]    op_rdata_i = '0;

  smb_host_seq #(.DATA_BYTES(DB)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  // bus engine / slave model state
  logic [6:0] slave_a = 7'h2A;
  int nack_at = -1, wr_cnt = 0, rd_ptr = 0, gap = 0;
  bit first_wr = 0;
  logic [7:0] rd_src [48];
  int log_k [64]; logic [7:0] log_b [64]; int log_n = 0;
  int exp_k [64]; logic [7:0] exp_b [64]; int exp_n = 0;

  initial forever begin
    @(negedge clk_i);
    if (op_done_i) op_done_i = 1'b0;
    else if (op_valid_o) begin
      if (gap != 0) gap--;
      else begin
        gap = ENG_GAP;
        op_nack_i = 1'b0;
        op_rdata_i = '0;
        case (op_kind_o)
          3'd0: first_wr = 1;
          3'd1: begin
            if (first_wr) op_nack_i = (op_wdata_o[7:1] != slave_a);
            else begin
              if (wr_cnt == nack_at) op_nack_i = 1'b1;
              wr_cnt++;
            end
            first_wr = 0;
          end
          3'd2, 3'd3: begin op_rdata_i = rd_src[rd_ptr]; rd_ptr++; end
          default: ;
        endcase
        if (log_n < 64) begin log_k[log_n] = op_kind_o; log_b[log_n] = op_wdata_o; end
        log_n++;
        op_done_i = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = AW'(a); reg_wdata_i = 8'(d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = AW'(a);
    #1 d = reg_rdata_o;
  endtask

  task automatic ex(input int k, input int b);
    exp_k[exp_n] = k; exp_b[exp_n] = 8'(b); exp_n++;
  endtask

  task automatic clr_logs();
    log_n = 0; exp_n = 0; rd_ptr = 0; wr_cnt = 0; nack_at = -1; slave_a = 7'h2A;
  endtask

  task automatic run_txn(input int p);
    logic [7:0] v;
    wr(0, p);
    for (int i = 0; i < 3000; i++) begin
      rd(0, v);
      if (v == 8'h00) break;
    end
  endtask

  task automatic chk_log(input string req);
    int bad_i;
    bad_i = -1;
    if (log_n != exp_n) bad_i = 999;
    else
      for (int i = 0; i < exp_n; i++)
        if (bad_i < 0 && (log_k[i] != exp_k[i] || (exp_k[i] == 1 && log_b[i] != exp_b[i]))) bad_i = i;
    n_chk++;
    if (bad_i == 999) begin
      n_bad++;
      $display("FAIL %s primitive count: actual %0d expected %0d", req, log_n, exp_n);
    end else if (bad_i >= 0) begin
      n_bad++;
      $display("FAIL %s primitive %0d: actual kind %0d byte 0x%0h expected kind %0d byte 0x%0h",
               req, bad_i, log_k[bad_i], log_b[bad_i], exp_k[bad_i], exp_b[bad_i]);
    end
  endtask

  task automatic chk_reg(input string req, input int a, input int e);
    logic [7:0] v;
    rd(a, v);
    chk(req, $sformatf("reg 0x%0h", a), v, e);
  endtask

  task automatic t_reset();
    chk("R1", "op_valid", op_valid_o, 0);
    for (int a = 0; a < CNT + 4; a += 3) chk_reg("R1", a, 0);
    chk_reg("R1", 1, 0);
  endtask

  task automatic t_quick();
    clr_logs(); wr(2, 8'h54);
    ex(0, 0); ex(1, 8'h54); ex(4, 0);
    run_txn(8'h02);
    chk_log("R3"); chk_reg("R2", 1, 8'h80); chk_reg("R2", 0, 0);
    clr_logs();
    ex(0, 0); ex(1, 8'h55); ex(4, 0);
    run_txn(8'h03);
    chk_log("R3");
  endtask

  task automatic t_write_bytes();
    clr_logs(); wr(3, 8'h31);
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h31); ex(4, 0);
    run_txn(8'h04);
    chk_log("R4");
    clr_logs(); wr(4, 8'hA5);
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h31); ex(1, 8'hA5); ex(4, 0);
    run_txn(8'h06);
    chk_log("R4"); chk_reg("R4", 1, 8'h80);
    clr_logs(); wr(4, 8'h78); wr(5, 8'h56);
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h31); ex(1, 8'h78); ex(1, 8'h56); ex(4, 0);
    run_txn(8'h08);
    chk_log("R6");
  endtask

  task automatic t_reads();
    clr_logs(); rd_src[0] = 8'h9E;
    ex(0, 0); ex(1, 8'h55); ex(3, 0); ex(4, 0);
    run_txn(8'h05);
    chk_log("R5"); chk_reg("R5", 4, 8'h9E);
    clr_logs(); wr(3, 8'h40); rd_src[0] = 8'h34; rd_src[1] = 8'h12;
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h40); ex(0, 0); ex(1, 8'h55); ex(2, 0); ex(3, 0); ex(4, 0);
    run_txn(8'h09);
    chk_log("R5"); chk_reg("R6", 4, 8'h34); chk_reg("R6", 5, 8'h12); chk_reg("R2", 1, 8'h80);
  endtask

  task automatic t_proc_call();
    clr_logs(); wr(3, 8'h50); wr(4, 8'h11); wr(5, 8'h22); rd_src[0] = 8'hCD; rd_src[1] = 8'hAB;
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h50); ex(1, 8'h11); ex(1, 8'h22);
    ex(0, 0); ex(1, 8'h55); ex(2, 0); ex(3, 0); ex(4, 0);
    run_txn(8'h0C);
    chk_log("R9"); chk_reg("R9", 4, 8'hCD); chk_reg("R9", 5, 8'hAB);
  endtask

  task automatic t_block_write();
    clr_logs(); wr(3, 8'h60); wr(CNT, DB);
    for (int i = 0; i < DB; i++) wr(4 + i, i * 3 + 1);
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h60); ex(1, DB);
    for (int i = 0; i < DB; i++) ex(1, i * 3 + 1);
    ex(4, 0);
    run_txn(8'h0A);
    chk_log("R7"); chk_reg("R7", 1, 8'h80);
    clr_logs(); wr(CNT, 0); run_txn(8'h0A);
    chk_log("R7"); chk_reg("R7", 1, 8'h93);
    clr_logs(); wr(CNT, DB + 1); run_txn(8'h0A);
    chk_log("R7"); chk_reg("R7", 1, 8'h93);
  endtask

  task automatic t_block_read();
    clr_logs(); wr(3, 8'h70);
    rd_src[0] = 8'd3; rd_src[1] = 8'hE1; rd_src[2] = 8'hE2; rd_src[3] = 8'hE3;
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h70); ex(0, 0); ex(1, 8'h55);
    ex(2, 0); ex(2, 0); ex(2, 0); ex(3, 0); ex(4, 0);
    run_txn(8'h0B);
    chk_log("R8"); chk_reg("R8", CNT, 3); chk_reg("R8", 4, 8'hE1); chk_reg("R8", 6, 8'hE3);
    chk_reg("R8", 1, 8'h80);
    clr_logs(); rd_src[0] = 8'(DB + 1);
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h70); ex(0, 0); ex(1, 8'h55); ex(2, 0); ex(4, 0);
    run_txn(8'h0B);
    chk_log("R8"); chk_reg("R8", 1, 8'h91);
    clr_logs(); rd_src[0] = 8'd0;
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h70); ex(0, 0); ex(1, 8'h55); ex(2, 0); ex(4, 0);
    run_txn(8'h0B);
    chk_log("R8"); chk_reg("R8", 1, 8'h91);
  endtask

  task automatic t_nacks();
    clr_logs(); slave_a = 7'h11; wr(3, 8'h31); wr(4, 8'hA5);
    ex(0, 0); ex(1, 8'h54); ex(4, 0);
    run_txn(8'h06);
    chk_log("R10"); chk_reg("R10", 1, 8'h90);
    clr_logs(); nack_at = 1;
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h31); ex(1, 8'hA5); ex(4, 0);
    run_txn(8'h06);
    chk_log("R14"); chk_reg("R14", 1, 8'h91);
  endtask

  task automatic t_unsup();
    clr_logs(); run_txn(8'h0E);
    chk_log("R11"); chk_reg("R11", 1, 8'h99); chk_reg("R11", 0, 0);
  endtask

  task automatic t_busy_write();
    clr_logs(); wr(3, 8'h31); wr(4, 8'hA5);
    ex(0, 0); ex(1, 8'h54); ex(1, 8'h31); ex(1, 8'hA5); ex(4, 0);
    wr(0, 8'h06);
    wr(0, 8'h0A);
    run_txn(8'h00);
    repeat (20) @(negedge clk_i);
    chk_log("R12"); chk_reg("R12", 0, 0); chk("R12", "op_valid", op_valid_o, 0);
  endtask

  task automatic t_readback();
    wr(2, 8'h5B); wr(3, 8'hC3); wr(4 + DB - 1, 8'h7E); wr(CNT, 8'h2F);
    wr(CNT + 1, 8'h19); wr(CNT + 2, 8'h8A); wr(CNT + 3, 8'h4D);
    chk_reg("R13", 2, 8'h5B); chk_reg("R13", 3, 8'hC3); chk_reg("R13", 4 + DB - 1, 8'h7E);
    chk_reg("R13", CNT, 8'h2F); chk_reg("R13", CNT + 1, 8'h19);
    chk_reg("R13", CNT + 2, 8'h8A); chk_reg("R13", CNT + 3, 8'h4D);
    wr(2, 8'h54);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    wr(2, 8'h54);
    t_quick();
    t_write_bytes();
    t_reads();
    t_proc_call();
    t_block_write();
    t_block_read();
    t_nacks();
    t_unsup();
    t_busy_write();
    t_readback();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule